// File: doc/BRIEF.md
# Timer Event Flag Bank with Privileged Clear

This block holds the pending-event flags of a real-time timer peripheral in one 32-bit register. Seven hardware sources feed it with single-cycle pulses: four compare units, two free-running counter overflows, and a timebase fault monitor. The timebase fault monitor reports when it has dropped the external-timebase selection because an external clock edge went missing. A pulse latches its flag, and the flag stays set until software clears it. A flag is latched even when its interrupt is disabled.

Software reads the register with a single-cycle read strobe. It clears flags with a single-cycle write strobe under a write-one-to-clear rule. Clearing takes effect only when the write is marked privileged.

Each source also has an interrupt request output. The request is a registered AND of the source's flag and its bit of the enable mask input.

Top module: `irq_flag_bank`

## Requirements
- R1: Read bit layout: compare flags 0..3 sit at bits 0..3, the timebase flag at bit 16, the counter 0 overflow flag at bit 17 and the counter 1 overflow flag at bit 18. The same seven sources use vector index 0..3 (compare), 4 (timebase), 5 (overflow 0) and 6 (overflow 1) on `irq_en` and `irq_req`.
- R2: A pulse on any source sets its flag at the next clock edge, whatever the state of `irq_en`. The flag stays set after the pulse ends.
- R3: A privileged write clears every flag whose bit in `bus_wdata` (layout of R1) is 1. Flags whose bit is 0 keep their value.
- R4: A write with `bus_priv` low changes no flag.
- R5: Bits 31..19 and 15..4 always read as 0. Writing 1 to them has no effect.
- R6: The timebase flag is set only by `tb_hw_drop`. A pulse on `tb_sw_drop` never sets it.
- R7: While `rst_n` is low, all flags and all interrupt requests go to 0.
- R8: If a source pulses in the same cycle as a privileged write that clears its flag, the flag ends up set.
- R9: After each clock edge, `irq_req` equals the flag vector after that edge ANDed with `irq_en` as sampled at that edge. A request stays high until its flag is cleared or its enable drops.
- R10: `bus_rdata` shows the flags as they stood before any set or clear in the same cycle. It reads 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_match | input | 4 | Compare-match pulses, one per compare unit |
| ovf0_pulse | input | 1 | Counter 0 overflow pulse |
| ovf1_pulse | input | 1 | Counter 1 overflow pulse |
| tb_hw_drop | input | 1 | Hardware dropped the external-timebase selection after a missing edge |
| tb_sw_drop | input | 1 | Software dropped the external-timebase selection |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_priv | input | 1 | Write is made in privileged mode |
| bus_wdata | input | 32 | Write data, 1 bits select flags to clear |
| bus_rdata | output | 32 | Read data |
| irq_en | input | 7 | Per-source interrupt enable mask |
| irq_req | output | 7 | Per-source interrupt request |

## Verification
Two collisions can happen in the same cycle: a hardware set pulse meeting a privileged write-one-to-clear of the same bit, and a read strobe meeting a set or clear. To provoke both, the sweep walks every 7-bit preset pattern against every 7-bit clear mask. In the cycle of the write, it pulses a subset of sources that overlaps the clear mask and holds the read strobe high. The privilege bit is toggled across the sweep. The read in the collision cycle must return the preset value. The read that follows must equal (preset AND NOT mask) OR pulses for a privileged write, and preset OR pulses for a user write.

// File: rtl/irq_flag_bank.sv
module irq_flag_bank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  cmp_match,
  input  logic        ovf0_pulse,
  input  logic        ovf1_pulse,
  input  logic        tb_hw_drop,
  input  logic        tb_sw_drop,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic        bus_priv,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [6:0]  irq_en,
  output logic [6:0]  irq_req
);

  localparam int SRC_N = 7;

  logic [SRC_N-1:0] flag_q;
  logic [SRC_N-1:0] set_v;
  logic [SRC_N-1:0] clr_v;
  logic [SRC_N-1:0] flag_d;
  logic             unused_bits;

  assign set_v  = {ovf1_pulse, ovf0_pulse, tb_hw_drop, cmp_match};
  assign clr_v  = (bus_wr && bus_priv) ? {bus_wdata[18:16], bus_wdata[3:0]} : '0;
  assign flag_d = (flag_q & ~clr_v) | set_v;

  assign bus_rdata = bus_rd ? {13'd0, flag_q[6:4], 12'd0, flag_q[3:0]} : 32'd0;

  assign unused_bits = ^{tb_sw_drop, bus_wdata[31:19], bus_wdata[15:4]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= '0;
      irq_req <= '0;
    end else begin
      flag_q  <= flag_d;
      irq_req <= flag_d & irq_en;
    end
  end

endmodule

// File: rtl/irq_flag_bank_chk.sv
module irq_flag_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  cmp_match,
  input logic        ovf0_pulse,
  input logic        ovf1_pulse,
  input logic        tb_hw_drop,
  input logic        bus_wr,
  input logic        bus_priv,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [6:0]  irq_en,
  input logic [6:0]  irq_req,
  input logic [6:0]  flag_q
);

  logic [6:0] src_v;
  logic [6:0] wmask;
  assign src_v = {ovf1_pulse, ovf0_pulse, tb_hw_drop, cmp_match};
  assign wmask = {bus_wdata[18:16], bus_wdata[3:0]};

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (flag_q == 7'd0 && irq_req == 7'd0));

  // R2 R8
  set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_v != 7'd0) |=> ((flag_q & $past(src_v)) == $past(src_v)));

  // R4
  user_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_priv) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R3
  priv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_priv && src_v == 7'd0) |=> ((flag_q & $past(wmask)) == 7'd0));

  // R5
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & 32'hFFF8_FFF0) == 32'd0);

  // R6
  tb_hw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tb_hw_drop |=> !$rose(flag_q[4]));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_req == (flag_q & $past(irq_en))));

endmodule

bind irq_flag_bank irq_flag_bank_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmp_match  (cmp_match),
  .ovf0_pulse (ovf0_pulse),
  .ovf1_pulse (ovf1_pulse),
  .tb_hw_drop (tb_hw_drop),
  .bus_wr     (bus_wr),
  .bus_priv   (bus_priv),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .irq_en     (irq_en),
  .irq_req    (irq_req),
  .flag_q     (flag_q)
);

// File: tb/irq_flag_bank_tb.sv
`timescale 1ns/1ps
module irq_flag_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cmp_match;
  logic        ovf0_pulse, ovf1_pulse, tb_hw_drop, tb_sw_drop;
  logic        bus_rd, bus_wr, bus_priv;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [6:0]  irq_en;
  logic [6:0]  irq_req;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_flag_bank u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_match(cmp_match),
    .ovf0_pulse(ovf0_pulse), .ovf1_pulse(ovf1_pulse),
    .tb_hw_drop(tb_hw_drop), .tb_sw_drop(tb_sw_drop),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_priv(bus_priv),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_en(irq_en), .irq_req(irq_req)
  );

  function automatic logic [31:0] lay(input logic [6:0] v);
    return {13'd0, v[6:4], 12'd0, v[3:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cmp_match = 4'd0; ovf0_pulse = 0; ovf1_pulse = 0;
    tb_hw_drop = 0; tb_sw_drop = 0;
    bus_rd = 0; bus_wr = 0; bus_priv = 0; bus_wdata = 32'd0;
  endtask

  task automatic pulse(input logic [6:0] v);
    cmp_match = v[3:0]; tb_hw_drop = v[4]; ovf0_pulse = v[5]; ovf1_pulse = v[6];
  endtask

  task automatic next_edge();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(150000 * 5);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle();
    irq_en = 7'h7F;
    rst_n = 0;
    pulse(7'h7F);
    repeat (3) @(posedge clk);
    #1; rst_n = 1; idle();
    bus_rd = 1;
    @(negedge clk);
    // R7 reset state
    chk(bus_rdata == 32'd0, "R7 flags after reset", bus_rdata, 32'd0);
    chk(irq_req == 7'd0, "R7 irq after reset", {25'd0, irq_req}, 32'd0);
    next_edge();

    for (int p = 0; p < 128; p++) begin
      for (int m = 0; m < 128; m++) begin
        logic [6:0] pv, mv, sv, en, expv;
        logic       pr;
        pv = p[6:0]; mv = m[6:0];
        en = mv ^ 7'h55;
        pr = pv[0] ^ mv[0] ^ mv[3];
        sv = mv & 7'h5A & {7{pv[1]}};
        expv = pr ? ((pv & ~mv) | sv) : (pv | sv);
        irq_en = en;

        bus_wr = 1; bus_priv = 1; bus_wdata = 32'hFFFF_FFFF;
        next_edge();

        pulse(pv);
        @(negedge clk);
        // R10 no read strobe
        chk(bus_rdata == 32'd0, "R10 idle read", bus_rdata, 32'd0);
        next_edge();

        bus_rd = 1;
        @(negedge clk);
        // R1 R2 layout and latching regardless of enable
        chk(bus_rdata == lay(pv), "R1 R2 preset read", bus_rdata, lay(pv));
        // R9
        chk(irq_req == (pv & en), "R9 irq after preset", {25'd0, irq_req}, {25'd0, pv & en});
        next_edge();

        bus_rd = 1; bus_wr = 1; bus_priv = pr; tb_sw_drop = 1;
        bus_wdata = lay(mv) | (mv[2] ? 32'hFFF8_FFF0 : 32'd0);
        pulse(sv);
        @(negedge clk);
        // R10 read shows pre-update value
        chk(bus_rdata == lay(pv), "R10 collision read", bus_rdata, lay(pv));
        next_edge();

        bus_rd = 1;
        @(negedge clk);
        // R3 R4 R5 R6 R8 outcome of write with concurrent set
        chk(bus_rdata == lay(expv), pr ? "R3 R8 R5 R6 priv write" : "R4 R8 R5 R6 user write",
            bus_rdata, lay(expv));
        chk(irq_req == (expv & en), "R9 irq after write", {25'd0, irq_req}, {25'd0, expv & en});
        next_edge();
      end
    end

    finish_run();
  end

endmodule